// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block walks one on-chip PLL through a safe reprogramming sequence. A requester hands it a reference divider, feedback multiplier and output divider. The block first checks that the resulting VCO and output frequencies are legal. It then switches the PLL's clock mux to the slow (bypass) path and holds the PLL in reset. While reset is held it writes the divisor and loop-bandwidth fields and lets them settle for a fixed time. It then releases reset, polls the lock indication at a fixed interval and, once lock is seen, returns the mux to the PLL output.

The request enters over a valid/ready handshake. `req_ready` is high only while the sequencer is idle, and a request transfers on a clock edge where both `req_valid` and `req_ready` are high. No back-pressure is applied in the other direction: `seq_done` and `seq_err` are one-cycle pulses that are not held, so a requester that needs them must sample them. The PLL-side outputs are plain level registers meant to drive the PLL's configuration pins directly.

The settle and poll times are given in microseconds and converted to cycle counts from a clock-frequency parameter. A bounded count of lock polls guards against a PLL that never locks.

Top module: `pll_prog_seq`

## Requirements
- R1: `req_ready` is 1 only in the idle state. A request is taken on an edge with `req_valid` and `req_ready` both high. A `req_valid` asserted while the block is busy has no effect on the running sequence or its field outputs.
- R2: The block rejects a request when any of these holds: NR is outside 1..64, NF is outside 1..8192, or NO is outside 1..16. It also rejects NO values that are neither 1 nor even. Finally it rejects the request when ref*NF/NR lies outside [VCO_MIN, VCO_MAX] or ref*NF/(NR*NO) lies outside [OUT_MIN, OUT_MAX], with both comparisons exact and limits inclusive. On rejection `seq_err` pulses for one cycle, one cycle after acceptance, and the mode, reset and field outputs keep their values.
- R3: For an accepted request, the mode goes to slow one cycle after acceptance, `pll_rst` rises two cycles after acceptance, and the field outputs take their new values three cycles after acceptance. `pll_rst` is never high unless the mode is slow.
- R4: The field outputs carry value minus one: `pll_nr_fld` = NR-1 (6 bits), `pll_no_fld` = NO-1 (4 bits), `pll_nf_fld` = NF-1 (13 bits).
- R5: `pll_bw_fld` (12 bits) equals (NF >> 1) - 1.
- R6: `pll_rst` stays high for SETTLE_US*CLK_MHZ cycles after the fields are written, then falls.
- R7: After reset falls, `pll_lock` is sampled every POLL_US*CLK_MHZ cycles. At the first sample that finds it high, the mode becomes normal and `seq_done` pulses for one cycle on the same edge.
- R8: If MAX_POLLS samples in a row find `pll_lock` low, `seq_err` pulses for one cycle on the last of them. The mode stays slow, `pll_rst` stays low and `seq_done` does not pulse.
- R9: `pll_mode` uses 0 for slow and 1 for normal. After reset the mode is slow, `pll_rst` is 0, all fields are 0 and `req_ready` is 1.
- R10: `seq_done` and `seq_err` never pulse together, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_nr | input | 7 | Reference divider NR, 1..64 |
| req_nf | input | 14 | Feedback multiplier NF, 1..8192 |
| req_no | input | 5 | Output divider NO, 1..16 |
| pll_lock | input | 1 | Lock indication from the PLL |
| pll_rst | output | 1 | PLL reset, active high |
| pll_mode | output | 2 | Clock mux select: 0 slow, 1 normal |
| pll_nr_fld | output | 6 | NR-1 |
| pll_no_fld | output | 4 | NO-1 |
| pll_nf_fld | output | 13 | NF-1 |
| pll_bw_fld | output | 12 | Loop bandwidth field, (NF>>1)-1 |
| seq_done | output | 1 | One-cycle pulse on successful completion |
| seq_err | output | 1 | One-cycle pulse on rejection or lock timeout |

## Verification
Counting from the edge that accepts a request, the expected timing is as follows. A rejection shows on `seq_err` 1 edge later. An accepted request moves the mode at edge 1, raises reset at edge 2, writes the fields at edge 3 and drops reset at edge 3+S. It completes at edge 3+S+k*P, where k is the first poll that finds lock, or times out at edge 3+S+MAX_POLLS*P. The bench computes these offsets from the parameters and from its own PLL model, which raises lock a fixed delay after reset falls. It counts edges from acceptance and samples on the falling edge that follows each edge of interest. Each check therefore compares the exact cycle on which a result should first appear, along with the cycle just before it.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  localparam int unsigned NR_FW = 6;
  localparam int unsigned NO_FW = 4;
  localparam int unsigned NF_FW = 13;
  localparam int unsigned BW_FW = 12;

  localparam logic [1:0] MODE_SLOW   = 2'd0;
  localparam logic [1:0] MODE_NORMAL = 2'd1;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_RST_ON,
    S_WRITE,
    S_SETTLE,
    S_LOCK
  } seq_state_e;

  typedef struct packed {
    logic [NR_FW:0] nr;
    logic [NF_FW:0] nf;
    logic [NO_FW:0] no;
  } pll_req_t;

endpackage

// File: rtl/pll_req_check.sv
module pll_req_check
  import pll_seq_pkg::*;
#(
  parameter int unsigned REF_KHZ     = 24000,
  parameter int unsigned VCO_MIN_KHZ = 440000,
  parameter int unsigned VCO_MAX_KHZ = 2200000,
  parameter int unsigned OUT_MIN_KHZ = 27500,
  parameter int unsigned OUT_MAX_KHZ = 2200000
) (
  input  pll_req_t req,
  output logic     ok
);
  localparam logic [63:0] NR_LIM = 64'(1) << NR_FW;
  localparam logic [63:0] NF_LIM = 64'(1) << NF_FW;
  localparam logic [63:0] NO_LIM = 64'(1) << NO_FW;

  logic [63:0] nr_w, nf_w, no_w, ref_term;
  logic        nr_ok, nf_ok, no_ok, vco_ok, out_ok;

  always_comb begin
    nr_w     = 64'(req.nr);
    nf_w     = 64'(req.nf);
    no_w     = 64'(req.no);
    ref_term = 64'(REF_KHZ) * nf_w;
    nr_ok    = (nr_w != 0) && (nr_w <= NR_LIM);
    nf_ok    = (nf_w != 0) && (nf_w <= NF_LIM);
    no_ok    = (no_w != 0) && (no_w <= NO_LIM) && ((no_w == 1) || !req.no[0]);
    // exact compare without division: ref*NF against limit*NR (and *NO)
    vco_ok   = (ref_term >= 64'(VCO_MIN_KHZ) * nr_w) &&
               (ref_term <= 64'(VCO_MAX_KHZ) * nr_w);
    out_ok   = (ref_term >= 64'(OUT_MIN_KHZ) * nr_w * no_w) &&
               (ref_term <= 64'(OUT_MAX_KHZ) * nr_w * no_w);
    ok       = nr_ok && nf_ok && no_ok && vco_ok && out_ok;
  end
endmodule

// File: rtl/pll_field_encode.sv
module pll_field_encode
  import pll_seq_pkg::*;
(
  input  pll_req_t          req,
  output logic [NR_FW-1:0]  nr_fld,
  output logic [NO_FW-1:0]  no_fld,
  output logic [NF_FW-1:0]  nf_fld,
  output logic [BW_FW-1:0]  bw_fld
);
  always_comb begin
    nr_fld = NR_FW'(req.nr - 1'b1);
    no_fld = NO_FW'(req.no - 1'b1);
    nf_fld = NF_FW'(req.nf - 1'b1);
    bw_fld = BW_FW'((req.nf >> 1) - 1'b1);
  end
endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/pll_prog_seq.sv
module pll_prog_seq
  import pll_seq_pkg::*;
#(
  parameter int unsigned REF_KHZ     = 24000,
  parameter int unsigned CLK_MHZ     = 100,
  parameter int unsigned SETTLE_US   = 10,
  parameter int unsigned POLL_US     = 1,
  parameter int unsigned MAX_POLLS   = 256,
  parameter int unsigned VCO_MIN_KHZ = 440000,
  parameter int unsigned VCO_MAX_KHZ = 2200000,
  parameter int unsigned OUT_MIN_KHZ = 27500,
  parameter int unsigned OUT_MAX_KHZ = 2200000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [NR_FW:0]   req_nr,
  input  logic [NF_FW:0]   req_nf,
  input  logic [NO_FW:0]   req_no,
  input  logic             pll_lock,
  output logic             pll_rst,
  output logic [1:0]       pll_mode,
  output logic [NR_FW-1:0] pll_nr_fld,
  output logic [NO_FW-1:0] pll_no_fld,
  output logic [NF_FW-1:0] pll_nf_fld,
  output logic [BW_FW-1:0] pll_bw_fld,
  output logic             seq_done,
  output logic             seq_err
);
  localparam int unsigned SETTLE_CYC = SETTLE_US * CLK_MHZ;
  localparam int unsigned POLL_CYC   = POLL_US * CLK_MHZ;
  localparam int unsigned TMAX       = (SETTLE_CYC > POLL_CYC) ? SETTLE_CYC : POLL_CYC;
  localparam int unsigned TW         = $clog2(TMAX + 1);
  localparam int unsigned PW         = $clog2(MAX_POLLS + 1);
  localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0] POLL_LD   = TW'(POLL_CYC - 1);
  localparam logic [PW-1:0] LAST_POLL = PW'(MAX_POLLS - 1);

  seq_state_e       state;
  pll_req_t         req_q;
  logic             req_ok;
  logic [NR_FW-1:0] enc_nr;
  logic [NO_FW-1:0] enc_no;
  logic [NF_FW-1:0] enc_nf;
  logic [BW_FW-1:0] enc_bw;
  logic             tmr_load, tmr_zero;
  logic [TW-1:0]    tmr_val;
  logic [PW-1:0]    poll_cnt;

  pll_req_check #(
    .REF_KHZ(REF_KHZ), .VCO_MIN_KHZ(VCO_MIN_KHZ), .VCO_MAX_KHZ(VCO_MAX_KHZ),
    .OUT_MIN_KHZ(OUT_MIN_KHZ), .OUT_MAX_KHZ(OUT_MAX_KHZ)
  ) u_check (
    .req(req_q),
    .ok (req_ok)
  );

  pll_field_encode u_enc (
    .req   (req_q),
    .nr_fld(enc_nr),
    .no_fld(enc_no),
    .nf_fld(enc_nf),
    .bw_fld(enc_bw)
  );

  // one down-counter serves both the settle window and the poll interval
  always_comb begin
    tmr_load = (state == S_WRITE) ||
               ((state == S_SETTLE || state == S_LOCK) && tmr_zero);
    tmr_val  = (state == S_WRITE) ? SETTLE_LD : POLL_LD;
  end

  pll_seq_timer #(.W(TW)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_zero)
  );

  assign req_ready = (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      req_q      <= '0;
      pll_mode   <= MODE_SLOW;
      pll_rst    <= 1'b0;
      pll_nr_fld <= '0;
      pll_no_fld <= '0;
      pll_nf_fld <= '0;
      pll_bw_fld <= '0;
      seq_done   <= 1'b0;
      seq_err    <= 1'b0;
      poll_cnt   <= '0;
    end else begin
      seq_done <= 1'b0;
      seq_err  <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            req_q <= '{nr: req_nr, nf: req_nf, no: req_no};
            state <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (req_ok) begin
            pll_mode <= MODE_SLOW;
            state    <= S_RST_ON;
          end else begin
            seq_err <= 1'b1;
            state   <= S_IDLE;
          end
        end
        S_RST_ON: begin
          pll_rst <= 1'b1;
          state   <= S_WRITE;
        end
        S_WRITE: begin
          pll_nr_fld <= enc_nr;
          pll_no_fld <= enc_no;
          pll_nf_fld <= enc_nf;
          pll_bw_fld <= enc_bw;
          state      <= S_SETTLE;
        end
        S_SETTLE: begin
          if (tmr_zero) begin
            pll_rst  <= 1'b0;
            poll_cnt <= '0;
            state    <= S_LOCK;
          end
        end
        S_LOCK: begin
          if (tmr_zero) begin
            if (pll_lock) begin
              pll_mode <= MODE_NORMAL;
              seq_done <= 1'b1;
              state    <= S_IDLE;
            end else if (poll_cnt == LAST_POLL) begin
              seq_err <= 1'b1;
              state   <= S_IDLE;
            end else begin
              poll_cnt <= poll_cnt + 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk
  import pll_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       pll_lock,
  input logic       pll_rst,
  input logic [1:0] pll_mode,
  input logic       seq_done,
  input logic       seq_err
);
  a_r3_rst_only_in_slow: assert property (@(posedge clk) disable iff (!rst_n)
    pll_rst |-> (pll_mode == MODE_SLOW));

  a_r3_slow_before_rst: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_rst) |-> ($past(pll_mode) == MODE_SLOW));

  a_r1_idle_not_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !pll_rst);

  a_r7_done_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> $past(pll_lock));

  a_r7_normal_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pll_mode) && pll_mode == MODE_NORMAL) |-> seq_done);

  a_r8_err_reset_low: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> !pll_rst);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_done && seq_err));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  a_r10_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> !seq_err);
endmodule

bind pll_prog_seq pll_seq_chk u_seq_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .pll_lock (pll_lock),
  .pll_rst  (pll_rst),
  .pll_mode (pll_mode),
  .seq_done (seq_done),
  .seq_err  (seq_err)
);

// File: tb/test_pll_prog_seq.sv
module test_pll_prog_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ    = 10;
  localparam int SETTLE_US  = 10;
  localparam int POLL_US    = 1;
  localparam int MAX_POLLS  = 16;
  localparam int S          = SETTLE_US * CLK_MHZ;
  localparam int P          = POLL_US * CLK_MHZ;
  localparam int LOCK_DLY   = 35;
  localparam int K_POLL     = (LOCK_DLY + P - 1) / P;
  localparam int DONE_AT    = 3 + S + K_POLL * P;
  localparam int TMO_AT     = 3 + S + MAX_POLLS * P;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [6:0]  req_nr = '0;
  logic [13:0] req_nf = '0;
  logic [4:0]  req_no = '0;
  logic        pll_lock = 1'b0;
  logic        pll_rst;
  logic [1:0]  pll_mode;
  logic [5:0]  pll_nr_fld;
  logic [3:0]  pll_no_fld;
  logic [12:0] pll_nf_fld;
  logic [11:0] pll_bw_fld;
  logic        seq_done, seq_err;

  int total = 0;
  int bad = 0;
  int lk_cnt = 0;
  logic lock_en = 1'b1;

  // bench-side record of what the ports should currently hold
  int prev_mode = 0, prev_nr = 0, prev_no = 0, prev_nf = 0, prev_bw = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_prog_seq #(
    .CLK_MHZ(CLK_MHZ), .SETTLE_US(SETTLE_US), .POLL_US(POLL_US), .MAX_POLLS(MAX_POLLS)
  ) i_pll_prog_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_nr(req_nr), .req_nf(req_nf), .req_no(req_no), .pll_lock(pll_lock),
    .pll_rst(pll_rst), .pll_mode(pll_mode), .pll_nr_fld(pll_nr_fld),
    .pll_no_fld(pll_no_fld), .pll_nf_fld(pll_nf_fld), .pll_bw_fld(pll_bw_fld),
    .seq_done(seq_done), .seq_err(seq_err)
  );

  // PLL model: lock rises LOCK_DLY cycles after reset is released
  always @(negedge clk) begin
    if (pll_rst) begin
      lk_cnt   <= 0;
      pll_lock <= 1'b0;
    end else begin
      lk_cnt   <= lk_cnt + 1;
      pll_lock <= lock_en && (lk_cnt + 1 >= LOCK_DLY);
    end
  end

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic fields_are(input string tag, input int nr, input int no, input int nf, input int bw);
    chk(pll_nr_fld == nr, {tag, " nr field"}, pll_nr_fld, nr);
    chk(pll_no_fld == no, {tag, " no field"}, pll_no_fld, no);
    chk(pll_nf_fld == nf, {tag, " nf field"}, pll_nf_fld, nf);
    chk(pll_bw_fld == bw, {tag, " bw field"}, pll_bw_fld, bw);
  endtask

  task automatic offer(input int nr, input int nf, input int no);
    @(negedge clk);
    req_nr = 7'(nr); req_nf = 14'(nf); req_no = 5'(no);
    req_valid = 1'b1;
    @(posedge clk);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk(pll_mode == 0, "R9 reset mode slow", pll_mode, 0);
    chk(pll_rst == 0, "R9 reset pll_rst low", pll_rst, 0);
    chk(req_ready == 1, "R9 reset ready", req_ready, 1);
    fields_are("R9 reset", 0, 0, 0, 0);
  endtask

  // accepted request; optionally offers a second request while busy (R1)
  task automatic run_ok(input int nr, input int nf, input int no, input bit inject);
    int enr, eno, enf, ebw;
    bit seen_done;
    enr = nr - 1; eno = no - 1; enf = nf - 1; ebw = (nf >> 1) - 1;
    seen_done = 0;
    offer(nr, nf, no);
    for (int n = 0; n < TMO_AT + 50; n++) begin
      @(negedge clk);
      if (n == 0) req_valid = 1'b0;
      if (inject && n == 10) begin
        req_nr = 7'd2; req_nf = 14'd100; req_no = 5'd1; req_valid = 1'b1;
      end
      if (n == 0) chk(seq_err == 0, "R2 legal request not rejected", seq_err, 0);
      if (n == 1) begin
        chk(pll_mode == 0, "R3 slow one cycle after accept", pll_mode, 0);
        chk(pll_rst == 0, "R3 reset not yet", pll_rst, 0);
        chk(req_ready == 0, "R1 busy not ready", req_ready, 0);
      end
      if (n == 2) begin
        chk(pll_rst == 1, "R3 reset two cycles after accept", pll_rst, 1);
        chk(pll_nf_fld == prev_nf, "R3 fields not yet written", pll_nf_fld, prev_nf);
      end
      if (n == 3) begin
        fields_are("R4", enr, eno, enf, ebw);
        chk(pll_bw_fld == ebw, "R5 bw field", pll_bw_fld, ebw);
      end
      if (n == 2 + S) chk(pll_rst == 1, "R6 reset held through settle", pll_rst, 1);
      if (n == 3 + S) chk(pll_rst == 0, "R6 reset released after settle", pll_rst, 0);
      if (n == DONE_AT - 1) chk(pll_mode == 0, "R7 still slow before lock poll", pll_mode, 0);
      if (seq_done) begin
        if (inject) req_valid = 1'b0;
        chk(n == DONE_AT, "R7 done cycle", n, DONE_AT);
        chk(pll_mode == 1, "R7 mode normal at done", pll_mode, 1);
        seen_done = 1;
        break;
      end
    end
    chk(seen_done, "R7 done seen", seen_done, 1);
    @(negedge clk);
    chk(seq_done == 0, "R10 done single cycle", seq_done, 0);
    chk(req_ready == 1, "R1 ready after done", req_ready, 1);
    if (inject) begin
      fields_are("R1 busy offer ignored", enr, eno, enf, ebw);
      repeat (5) @(negedge clk);
      chk(pll_rst == 0 && pll_mode == 1, "R1 no second run started", {pll_rst, pll_mode}, 1);
    end
    prev_mode = 1; prev_nr = enr; prev_no = eno; prev_nf = enf; prev_bw = ebw;
  endtask

  task automatic run_reject(input int nr, input int nf, input int no, input string why);
    offer(nr, nf, no);
    @(negedge clk);
    req_valid = 1'b0;
    chk(seq_err == 0, {"R2 ", why, " err not early"}, seq_err, 0);
    @(negedge clk);
    chk(seq_err == 1, {"R2 ", why, " rejected"}, seq_err, 1);
    chk(pll_mode == prev_mode, {"R2 ", why, " mode kept"}, pll_mode, prev_mode);
    chk(pll_rst == 0, {"R2 ", why, " no reset"}, pll_rst, 0);
    fields_are({"R2 ", why}, prev_nr, prev_no, prev_nf, prev_bw);
    @(negedge clk);
    chk(seq_err == 0, "R10 err single cycle", seq_err, 0);
    chk(req_ready == 1, "R1 ready after reject", req_ready, 1);
  endtask

  task automatic t_timeout();
    bit seen_err, seen_done;
    seen_err = 0; seen_done = 0;
    lock_en = 1'b0;
    offer(1, 50, 2);
    for (int n = 0; n < TMO_AT + 20; n++) begin
      @(negedge clk);
      if (n == 0) req_valid = 1'b0;
      if (seq_done) seen_done = 1;
      if (n == TMO_AT - 1) chk(seq_err == 0, "R8 no early timeout", seq_err, 0);
      if (seq_err) begin
        chk(n == TMO_AT, "R8 timeout cycle", n, TMO_AT);
        chk(pll_mode == 0, "R8 mode left slow", pll_mode, 0);
        chk(pll_rst == 0, "R8 reset low", pll_rst, 0);
        seen_err = 1;
        break;
      end
    end
    chk(seen_err, "R8 timeout seen", seen_err, 1);
    chk(!seen_done, "R8 no done on timeout", seen_done, 0);
    lock_en = 1'b1;
    prev_mode = 0; prev_nr = 0; prev_no = 1; prev_nf = 49; prev_bw = 24;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    run_ok(1, 50, 2, 0);                 // 1200 MHz VCO, 600 MHz out
    run_reject(1, 50, 3, "odd NO");
    run_reject(3, 276, 2, "VCO high");   // 2208 MHz
    run_ok(2, 100, 1, 0);                // NO of one
    run_ok(3, 275, 16, 0);               // VCO exactly at maximum, largest NO
    run_reject(1, 18, 1, "VCO low");     // 432 MHz
    run_reject(0, 50, 2, "NR zero");
    run_ok(3, 55, 1, 0);                 // VCO exactly at minimum
    run_ok(1, 60, 4, 1);                 // busy offer ignored
    t_timeout();
    run_reject(1, 50, 3, "after timeout");
    run_ok(1, 50, 2, 0);                 // recovery
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule